// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between three device interrupt request lines and a processor core. It latches each rising request as pending and picks the most urgent one. The processor is interrupted only when that request outranks every handler already in service. The fixed order puts the communications source first, the disk second and the printer last. A higher-priority request can break into a running lower-priority handler. Requests of equal or lower rank wait until the handlers above them have finished.

The core raises a take strobe once its current instruction is complete. In that same cycle the controller acknowledges the chosen device with a one-hot pulse and presents a vector index that names the service routine. The device then drops its line. When a handler finishes, the core pulses an end-of-service strobe. This retires the most urgent active handler, so control unwinds level by level to the preempted handler and finally to the user program. A global enable input masks all interrupt signalling to the core. Requests that arrive while it is low stay pending. Saving the program counter and registers is the core's job.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no requests, `irq_o` is 0, `ack_o` is 3'b000 and `vec_o` is 0.
- R2: Request bit 0 (communications) outranks bit 1 (disk), which outranks bit 2 (printer). When several are pending and none is in service, bit 0 is acknowledged first.
- R3: A rising edge on a request line sets that source's pending flag one clock later. The flag stays set while `gen_en_i` is 0, and the source is signalled once the enable returns.
- R4: `irq_o` is 1 only if some pending source has a strictly higher priority (lower bit index) than every source in service.
- R5: `ack_o` is one-hot, and it is nonzero only in a cycle where both `cpu_take_i` and `irq_o` are 1. In that cycle `vec_o` carries the acknowledged bit index: 0 for communications, 1 for disk, 2 for printer.
- R6: An acknowledge clears that source's pending flag. A request line that stays high after its acknowledge does not raise a new interrupt.
- R7: `eos_i` retires the highest-priority source in service. A pending source that was blocked only by that level is then signalled, and the remaining lower levels stay in service.
- R8: A higher-priority request preempts a lower handler in service. The sequence printer, communications, end, disk, end, end produces acknowledges in the order 2, 0, 1.
- R9: While `gen_en_i` is 0, `irq_o` is 0 and no acknowledge is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 3 | Device request lines; bit 0 communications, bit 1 disk, bit 2 printer |
| gen_en_i | input | 1 | Global interrupt enable |
| cpu_take_i | input | 1 | Core has completed an instruction and accepts an interrupt |
| eos_i | input | 1 | End-of-service strobe from the core |
| irq_o | output | 1 | Interrupt request to the core |
| ack_o | output | 3 | One-hot acknowledge to the chosen device |
| vec_o | output | 2 | Index of the service routine, valid with `ack_o` |

## Verification
The assertions check the following on every cycle:
- the acknowledge is one-hot;
- an acknowledge appears only with a take strobe and an active request;
- the enable masks the request;
- an acknowledged source has lost its pending flag one cycle later;
- an end-of-service removes exactly one in-service level.

Whole-history behaviour can only be shown by the bench's directed scenarios:
- the order of acknowledges in a nested sequence;
- a masked edge surviving until enable returns;
- equal or lower requests being held behind a handler;
- a held-high line not retriggering.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  // Number of request sources and derived vector width.
  localparam int NIRQ_SRC = 3;
  localparam int NIRQ_VW  = $clog2(NIRQ_SRC);
endpackage

// File: rtl/nirq_pend.sv
module nirq_pend #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic pend_q, pend_d;
    logic edge_seen;

    always_comb begin
      edge_seen = req_i[g] & ~req_q[g];
      pend_d    = pend_q;
      if (clr_i[g])       pend_d = 1'b0;
      else if (edge_seen) pend_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        pend_q   <= 1'b0;
        req_q[g] <= 1'b0;
      end else begin
        pend_q   <= pend_d;
        req_q[g] <= req_i[g];
      end
    end

    assign pend_o[g] = pend_q;

    // R6: acknowledge leaves the flag cleared on the next cycle
    a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_n)
      clr_i[g] |=> !pend_o[g]);
  end
endmodule

// File: rtl/nirq_arb.sv
module nirq_arb #(
  parameter int N  = 3,
  parameter int VW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  insvc_i,
  input  logic          gen_en_i,
  input  logic          take_i,
  output logic          irq_o,
  output logic [N-1:0]  ack_o,
  output logic [VW-1:0] vec_o
);
  logic [N-1:0] top_svc;
  logic [N-1:0] above;
  logic [N-1:0] cand;
  logic [N-1:0] win;

  always_comb begin
    top_svc = insvc_i & (~insvc_i + N'(1));
    above   = (insvc_i == '0) ? '1 : (top_svc - N'(1));
    cand    = pend_i & above;
    win     = cand & (~cand + N'(1));
    irq_o   = gen_en_i & (|cand);
    ack_o   = (irq_o && take_i) ? win : '0;
    vec_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ack_o[i]) vec_o = VW'(i);
    end
  end

  // R5: single acknowledge, only on take with a live request
  a_r5_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(ack_o));
  a_r5_ack_on_take: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|ack_o) |-> (take_i && irq_o));
  // R9: enable masks the core request
  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_n)
    !gen_en_i |-> (!irq_o && ack_o == '0));
endmodule

// File: rtl/nirq_isr.sv
module nirq_isr #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [N-1:0] ack_i,
  input  logic         eos_i,
  output logic [N-1:0] insvc_o
);
  logic [N-1:0] svc_q, svc_d;
  logic [N-1:0] top;

  always_comb begin
    top   = svc_q & (~svc_q + N'(1));
    svc_d = svc_q;
    if (eos_i) svc_d = svc_d & ~top;
    svc_d = svc_d | ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign insvc_o = svc_q;

  // R7: end-of-service without a new acknowledge drops exactly one level
  a_r7_eos_one_level: assert property (@(posedge clk_i) disable iff (!rst_n)
    (eos_i && (|svc_q) && ack_i == '0) |=>
      ($countones(svc_q) == $countones($past(svc_q)) - 1));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int N_SRC = NIRQ_SRC,
  localparam int VW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             gen_en_i,
  input  logic             cpu_take_i,
  input  logic             eos_i,
  output logic             irq_o,
  output logic [N_SRC-1:0] ack_o,
  output logic [VW-1:0]    vec_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] insvc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  nirq_pend #(.N(N_SRC)) i_pend (
    .clk_i (clk_i), .rst_n (rst_n), .req_i (req_i),
    .clr_i (ack_o), .pend_o (pend)
  );

  nirq_arb #(.N(N_SRC), .VW(VW)) i_arb (
    .clk_i (clk_i), .rst_n (rst_n), .pend_i (pend), .insvc_i (insvc),
    .gen_en_i (gen_en_i), .take_i (cpu_take_i),
    .irq_o (irq_o), .ack_o (ack_o), .vec_o (vec_o)
  );

  nirq_isr #(.N(N_SRC)) i_isr (
    .clk_i (clk_i), .rst_n (rst_n), .ack_i (ack_o),
    .eos_i (eos_i), .insvc_o (insvc)
  );

  // R4: a signalled request must come from a pending source
  a_r4_irq_has_pend: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (|pend));
  // R4: never signal while the most urgent level is already in service
  a_r4_top_blocks: assert property (@(posedge clk_i) disable iff (!rst_n)
    insvc[0] |-> !irq_o);
endmodule

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [2:0] req;
  logic       gen_en, take, eos;
  logic       irq;
  logic [2:0] ack;
  logic [1:0] vec;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req), .gen_en_i (gen_en),
    .cpu_take_i (take), .eos_i (eos), .irq_o (irq), .ack_o (ack), .vec_o (vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // core takes the interrupt; device drops its line after the acknowledge
  task automatic take_and_check(input string tag, input int exp_ack, input int exp_vec);
    take = 1'b1;
    #1;
    chk({tag, " ack"}, int'(ack), exp_ack);
    chk({tag, " vec"}, int'(vec), exp_vec);
    tick();
    take = 1'b0;
    req  = req & ~3'(exp_ack);
  endtask

  task automatic end_service();
    eos = 1'b1;
    tick();
    eos = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; req = '0; gen_en = 1'b1; take = 1'b0; eos = 1'b0;
    repeat (3) tick();
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 ack in reset", int'(ack), 0);
    rst_ni = 1'b1;
    repeat (3) tick();
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 vec after reset", int'(vec), 0);
  endtask

  task automatic t_priority();
    req = 3'b111;
    tick();
    chk("R2 irq all pending", int'(irq), 1);
    take_and_check("R2 first comms", 1, 0);
    chk("R4 blocked behind comms", int'(irq), 0);
    end_service();
    take_and_check("R2 then disk", 2, 1);
    end_service();
    take_and_check("R2 then printer", 4, 2);
    end_service();
    chk("R2 idle after drain", int'(irq), 0);
  endtask

  task automatic t_nest();
    req[2] = 1'b1; tick();
    take_and_check("R8 printer", 4, 2);
    req[0] = 1'b1; tick();
    chk("R8 comms preempts", int'(irq), 1);
    take_and_check("R8 comms", 1, 0);
    req[1] = 1'b1; tick();
    chk("R4 disk held behind comms", int'(irq), 0);
    end_service();
    chk("R7 disk released after comms end", int'(irq), 1);
    take_and_check("R8 disk", 2, 1);
    end_service();
    chk("R7 back to printer level", int'(irq), 0);
    end_service();
    chk("R8 back to user", int'(irq), 0);
  endtask

  task automatic t_equal_held();
    req[1] = 1'b1; tick();
    take_and_check("R4 disk", 2, 1);
    req[2] = 1'b1; tick(); req[2] = 1'b0;
    chk("R4 printer below disk", int'(irq), 0);
    req[1] = 1'b1; tick(); req[1] = 1'b0;
    chk("R4 equal disk held", int'(irq), 0);
    end_service();
    take_and_check("R7 equal disk after end", 2, 1);
    end_service();
    take_and_check("R7 printer last", 4, 2);
    end_service();
  endtask

  task automatic t_masked();
    gen_en = 1'b0;
    req[1] = 1'b1; tick(); req[1] = 1'b0; tick();
    chk("R9 irq masked", int'(irq), 0);
    take = 1'b1; #1;
    chk("R9 no ack masked", int'(ack), 0);
    tick(); take = 1'b0;
    gen_en = 1'b1; #1;
    chk("R3 held edge signalled", int'(irq), 1);
    @(negedge clk);
    take_and_check("R3 disk after enable", 2, 1);
    end_service();
  endtask

  task automatic t_level_hold();
    req[2] = 1'b1; tick();
    take = 1'b1; #1;
    chk("R6 printer ack", int'(ack), 4);
    tick(); take = 1'b0;
    end_service();
    tick();
    chk("R6 held line no retrigger", int'(irq), 0);
    req[2] = 1'b0; tick();
    chk("R6 idle", int'(irq), 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_priority();
    t_nest();
    t_equal_held();
    t_masked();
    t_level_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule